// File: doc/BRIEF.md
# Pipelined Byte-Writable Synchronous SRAM

This block is a single-port synchronous memory with a register on every input and a register on the read data. Each word is split into byte lanes. A lane can be written alone, or a global write can store the whole word whatever the lane selects say. Three synchronous chip-select lines, each with its own polarity, make banks easy to decode. An output enable that is not clocked gates a drive flag that stands for three-state control of the read data.

Address, control and write data are captured on a rising edge. On the next rising edge the write is performed or the word is read into the output register. A read issued right after a write to the same address therefore returns the new word. The drive flag has one register stage beyond the capture stage. When a read follows a deselected cycle, the output stays undriven for the clock in which that read sits in the input register.

Top module: `pipe_sram`

## Requirements
- R1: A word is 4 lanes of 8 bits; lane i is bits [8i+7:8i]. With `gwe_n` high, `bwe_n` low and `bsel_n[i]` low, lane i of the addressed word is written; lanes whose `bsel_n` bit is high keep their stored value.
- R2: With `gwe_n` low in a selected cycle, all four lanes are written, whatever the values of `bwe_n` and `bsel_n`.
- R3: Inputs are captured on the rising edge. A write captured at edge N is stored at edge N+1, so a read of the same address captured at edge N+1 returns the written word.
- R4: For a read captured at edge N, with `oe_n` low, `rdata_oe` is 1 and `rdata` holds the addressed word from edge N+1 until edge N+2.
- R5: The block is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Every other combination is a deselected cycle.
- R6: A deselected cycle writes nothing, whatever the write controls are.
- R7: After a deselected cycle or a write captured at edge N, from edge N+1 onward `rdata_oe` is 0 and `rdata` is 0.
- R8: When a read is captured at edge N and the cycle captured at edge N-1 was deselected, `rdata_oe` is 0 between edge N and edge N+1, even with `oe_n` low.
- R9: `oe_n` works with no clock: while it is high, `rdata_oe` and `rdata` are 0, and when it goes low again the held read data reappears within the same clock period.
- R10: A selected cycle is a read when `gwe_n` is high and no lane is write-enabled, that is when `bwe_n` is high or all `bsel_n` bits are high. Such a cycle stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| addr | input | ADDR_W | Word address |
| gwe_n | input | 1 | Global write, active low, writes all lanes |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane byte-write selects, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, zero while not driven |
| rdata_oe | output | 1 | Drive flag of the read data |

## Verification
Two things can fall on the same clock edge: storing a write held in the input register, and loading the output register for a read. Back-to-back write-then-read pairs to the same address provoke this, both for whole-word and for partial-lane writes. The word that comes out must be the newly merged one, computed lane by lane in the bench. The same edge can also carry the drive-mask rule, when a selected read follows one of the seven deselecting chip-select combinations. There the bench checks that the flag stays low for exactly one clock and then rises with the correct data.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

   // Kind of cycle held in the input register
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

endpackage

// File: rtl/pipe_sram_inreg.sv
module pipe_sram_inreg
   import pipe_sram_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              gwe_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  bsel_n,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   input  logic [DATA_W-1:0] wdata,
   output op_e               op_q,
   output logic [LANES-1:0]  lanes_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q
);

   logic             sel;
   logic [LANES-1:0] lane_en;
   op_e              op_d;

   // All three selects must be in their active state
   assign sel = !cs1_n && cs2 && !cs3_n;

   // Per-lane write enable: the global write overrides the byte selects
   for (genvar i = 0; i < LANES; i++) begin : g_lane_en
      assign lane_en[i] = sel && (!gwe_n || (!bwe_n && !bsel_n[i]));
   end

   always_comb begin
      if (!sel)          op_d = OP_IDLE;
      else if (|lane_en) op_d = OP_WRITE;
      else               op_d = OP_READ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= OP_IDLE;
         lanes_q <= '0;
      end else begin
         op_q    <= op_d;
         lanes_q <= lane_en;
      end
   end

   // Address and data need no reset; they are qualified by op_q
   always_ff @(posedge clk) begin
      addr_q  <= addr;
      wdata_q <= wdata;
   end

   assert_gw_all_lanes_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!cs1_n && cs2 && !cs3_n && !gwe_n) |=> (lanes_q == {LANES{1'b1}} && op_q == OP_WRITE));

   assert_bytewrite_lanes_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (!cs1_n && cs2 && !cs3_n && gwe_n && !bwe_n) |=> (lanes_q == ~$past(bsel_n)));

   assert_desel_no_write_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !(!cs1_n && cs2 && !cs3_n) |=> (lanes_q == '0 && op_q == OP_IDLE));

endmodule

// File: rtl/pipe_sram_array.sv
module pipe_sram_array
   import pipe_sram_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DEPTH  = 1 << ADDR_W,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  op_e               op_q,
   input  logic [LANES-1:0]  lanes_q,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rd_word
);

   // One storage column per byte lane so each lane writes on its own
   for (genvar i = 0; i < LANES; i++) begin : g_col
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (op_q == OP_WRITE && lanes_q[i])
            mem[addr_q] <= wdata_q[i*LANE_W +: LANE_W];
      end

      assign rd_word[i*LANE_W +: LANE_W] = mem[addr_q];
   end

endmodule

// File: rtl/pipe_sram_outstage.sv
module pipe_sram_outstage
   import pipe_sram_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               op_q,
   input  logic [DATA_W-1:0] rd_word,
   input  logic              oe_n,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe
);

   logic              drive_q;
   logic [DATA_W-1:0] dout_q;

   // The drive flag trails the input register by one stage, which masks
   // the output while a read that follows a deselect sits in capture.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= 1'b0;
         dout_q  <= '0;
      end else begin
         drive_q <= (op_q == OP_READ);
         if (op_q == OP_READ)
            dout_q <= rd_word;
      end
   end

   assign rdata_oe = !oe_n && drive_q;
   assign rdata    = rdata_oe ? dout_q : '0;

   assert_release_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != OP_READ) |=> !rdata_oe);

   assert_first_read_masked_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_READ && $past(op_q) == OP_IDLE) |-> !rdata_oe);

   assert_oe_async_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!rdata_oe && rdata == '0));

   assert_read_data_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_READ && !oe_n) |=> (oe_n || (rdata_oe && rdata == $past(rd_word))));

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
   import pipe_sram_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              gwe_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  bsel_n,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe
);

   // Elaboration-time parameter checks
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("pipe_sram: ADDR_W must lie in 1..12");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("pipe_sram: LANES and LANE_W must be positive");
   end

   op_e               op_q;
   logic [LANES-1:0]  lanes_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rd_word;

   pipe_sram_inreg #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_inreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .gwe_n   (gwe_n),
      .bwe_n   (bwe_n),
      .bsel_n  (bsel_n),
      .cs1_n   (cs1_n),
      .cs2     (cs2),
      .cs3_n   (cs3_n),
      .wdata   (wdata),
      .op_q    (op_q),
      .lanes_q (lanes_q),
      .addr_q  (addr_q),
      .wdata_q (wdata_q)
   );

   pipe_sram_array #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_array (
      .clk     (clk),
      .op_q    (op_q),
      .lanes_q (lanes_q),
      .addr_q  (addr_q),
      .wdata_q (wdata_q),
      .rd_word (rd_word)
   );

   pipe_sram_outstage #(
      .DATA_W (DATA_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_q     (op_q),
      .rd_word  (rd_word),
      .oe_n     (oe_n),
      .rdata    (rdata),
      .rdata_oe (rdata_oe)
   );

   assert_read_class_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!cs1_n && cs2 && !cs3_n && gwe_n && (bwe_n || &bsel_n)) |=> (op_q == OP_READ && lanes_q == '0));

   assert_select_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != OP_IDLE) |-> $past(!cs1_n && cs2 && !cs3_n));

endmodule

// File: tb/pipe_sram_tb.sv
module pipe_sram_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          gwe_n = 1'b1;
   logic          bwe_n = 1'b1;
   logic [3:0]    bsel_n = 4'hF;
   logic          cs1_n = 1'b1;
   logic          cs2 = 1'b0;
   logic          cs3_n = 1'b1;
   logic          oe_n = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          rdata_oe;

   int n_tests = 0;
   int n_fail  = 0;

   logic [31:0] model [DEPTH];
   logic        pend_oe = 1'b0;
   logic [31:0] pend_data = '0;
   string       pend_tag = "R7 reset";
   logic        prev_sel = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pipe_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .gwe_n(gwe_n), .bwe_n(bwe_n),
      .bsel_n(bsel_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .oe_n(oe_n),
      .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Issue one cycle at a falling edge; check the cycle issued before it
   task automatic op(input logic [AW-1:0] a, input logic g, input logic b,
                     input logic [3:0] bs, input logic c1, input logic c2,
                     input logic c3, input logic [31:0] wd, input string tag);
      logic       s;
      logic [3:0] lw;
      logic       rd;
      s = !c1 && c2 && !c3;
      for (int i = 0; i < 4; i++) lw[i] = s && (!g || (!b && !bs[i]));
      rd = s && (lw == 4'h0);
      addr = a; gwe_n = g; bwe_n = b; bsel_n = bs;
      cs1_n = c1; cs2 = c2; cs3_n = c3; wdata = wd;
      for (int i = 0; i < 4; i++)
         if (lw[i]) model[a][8*i +: 8] = wd[8*i +: 8];
      @(negedge clk);
      check(rdata_oe == pend_oe, {pend_tag, " drive flag"}, {31'd0, rdata_oe}, {31'd0, pend_oe});
      check(rdata == (pend_oe ? pend_data : 32'h0), {pend_tag, " data"}, rdata,
            pend_oe ? pend_data : 32'h0);
      if (rd && !prev_sel)
         check(rdata_oe == 1'b0, "R8 masked first read after deselect", {31'd0, rdata_oe}, 32'h0);
      pend_oe   = rd;
      pend_data = model[a];
      pend_tag  = tag;
      prev_sel  = s;
   endtask

   task automatic idle();
      op('0, 1'b1, 1'b1, 4'hF, 1'b1, 1'b0, 1'b1, 32'h0, "R7 deselected release");
   endtask

   task automatic rd_sel(input logic [AW-1:0] a, input string tag);
      op(a, 1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0, 32'hDEAD_BEEF, tag);
   endtask

   task automatic wr_all(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
      op(a, 1'b0, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0, d, tag);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = 'x;
      repeat (3) @(negedge clk);
      check(rdata_oe == 1'b0 && rdata == 32'h0, "R7 reset state", rdata, 32'h0);
      rst_n = 1'b1;

      // R2/R4: fill every word with a global write, read all back
      for (int a = 0; a < DEPTH; a++)
         wr_all(a[AW-1:0], 32'h0101_0101 * a ^ 32'hA55A_3CC3, "R7 write releases");
      idle();
      for (int a = 0; a < DEPTH; a++) rd_sel(a[AW-1:0], "R4 read sweep");

      // R1: every lane pattern, write then read back to back (R3)
      for (int p = 0; p < 16; p++) begin
         wr_all(p[AW-1:0], 32'h1111_1111 * p, "R2 base word");
         op(p[AW-1:0], 1'b1, 1'b0, p[3:0], 1'b0, 1'b1, 1'b0, ~(32'h0202_0202 * p), "R1 byte write");
         rd_sel(p[AW-1:0], "R1 R3 merged lanes read");
      end

      // R2: global write overrides deasserted selects and byte enable
      op(4'd3, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0, 32'hCAFE_F00D, "R2 override");
      rd_sel(4'd3, "R2 R3 read after override");

      // R10: byte enable high with selects low is a read and stores nothing
      op(4'd3, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 32'h0, "R10 byte enable off reads");
      rd_sel(4'd3, "R10 word unchanged");

      // R5/R6: all select combinations on a write, then read back
      for (int k = 0; k < 8; k++) begin
         op(4'd9, 1'b0, 1'b0, 4'h0, k[0], k[1], k[2], 32'h7700_0000 + k, "R5 R6 select decode");
         idle();
         rd_sel(4'd9, "R5 R6 R8 read after select sweep");
      end

      // R7/R8: deselected reads, then a selected read after each
      for (int k = 0; k < 8; k++) begin
         if (k != 2) begin
            op(4'd9, 1'b1, 1'b1, 4'hF, k[0], k[1], k[2], 32'h0, "R7 deselected read");
            rd_sel(4'd9, "R8 read after deselect");
         end
      end

      // R9: output enable toggled between clock edges
      rd_sel(4'd5, "R4 read before oe test");
      idle();
      oe_n = 1'b1;
      #1;
      check(rdata_oe == 1'b0 && rdata == 32'h0, "R9 oe high releases", rdata, 32'h0);
      oe_n = 1'b0;
      #1;
      check(rdata_oe == 1'b1 && rdata == model[5], "R9 oe low restores", rdata, model[5]);
      idle();
      idle();

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule